// File: doc/BRIEF.md
# Dual-Width 8B/10B Symbol Decoder

This block turns 10-bit line symbols back into bytes. Each symbol yields an 8-bit value, a flag that tells a control character from a data character, a flag for a symbol that is not a legal code, and a flag for a legal code that arrived with the wrong running disparity. The decode logic is combinational. One register stage holds the results, so every byte and its three flags leave the block in the same cycle.

A mode input selects one of two widths on each clock. In single-width mode the lower 10 input bits carry one symbol. In double-width mode the 20-bit input carries two symbols. The lower symbol is the earlier one on the line, and it is checked first. The disparity it ends with is the starting disparity for the upper symbol. The upper symbol's ending disparity carries into the next clock. A disparity error is reported, but the tracked disparity still follows the symbol that was received, so checking recovers on the next clean symbol.

Top module: `dual_dec10b8b`

## Requirements
- R1: In single-width mode, the symbol on `sym_i[9:0]` is decoded to `data_o[7:0]`. Symbol bit 0 is line bit a and is received first. The bits run a,b,c,d,e,i,f,g,h,j up to bit 9 (j). The 6-bit group abcdei gives byte bits [4:0] and the 4-bit group fghj gives byte bits [7:5]. Results appear on the outputs after the first rising edge that samples the input.
- R2: In double-width mode, `sym_i[9:0]` decodes to `data_o[7:0]` and `sym_i[19:10]` decodes to `data_o[15:8]`. Each lane has its own bit of `ctrl_o`, `code_err_o` and `disp_err_o` (bit 0 for the lower lane, bit 1 for the upper lane).
- R3: The `ctrl_o` bit of a lane is 1 for exactly the twelve control characters. These are K28.0 to K28.7 (bytes 8'h1C, 8'h3C, and so on up to 8'hFC), K23.7 (8'hF7), K27.7 (8'hFB), K29.7 (8'hFD) and K30.7 (8'hFE). It is 0 for data characters.
- R4: A symbol that is not a legal data or control code sets that lane's `code_err_o` bit. It forces the lane's byte to 8'h00 and its `ctrl_o` bit to 0. `code_err_o` and `disp_err_o` are never both 1 for a lane.
- R5: After reset the running disparity is negative. A legal code whose form does not match the current running disparity sets `disp_err_o` for its lane and still delivers the decoded byte.
- R6: After any symbol, the running disparity follows the received symbol, including a symbol that raised an error. A subblock with more ones than zeros makes it positive, one with fewer ones makes it negative, and a balanced subblock leaves it unchanged.
- R7: In double-width mode, the lower symbol is checked against the disparity carried from the previous clock. The upper symbol is checked against the disparity the lower symbol ends with, and the upper symbol's ending disparity is carried to the next clock.
- R8: In single-width mode, `sym_i[19:10]` is ignored. The upper lane's byte and its three flags are 0.
- R9: The mode input is sampled on every clock together with the symbols. Switching between widths from one clock to the next decodes each word in the width it was presented with, and the disparity chain stays intact.
- R10: For D.x.7, the alternate form (0111 after a negative 6-bit group, or 1000 after a positive one) is legal data only for x = 17, 18, 20 (negative) and x = 11, 13, 14 (positive). In those cases the primary form is a code error. After x = 23, 27, 29 or 30 the alternate form decodes as the control character. After any other x it is a code error.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_i | input | 1 | 1: double-width (two symbols), 0: single-width |
| sym_i | input | 20 | Symbol word, lower symbol in [9:0], upper symbol in [19:10] |
| data_o | output | 16 | Decoded bytes, lower lane in [7:0], upper lane in [15:8] |
| ctrl_o | output | 2 | Control-character flag per lane |
| code_err_o | output | 2 | Illegal-code flag per lane |
| disp_err_o | output | 2 | Running-disparity error flag per lane |

## Verification
The byte and all three flags of a lane are due together, one rising edge after the edge that samples `sym_i` and `dbl_i`. The bench applies each word at a falling edge and compares the outputs 1 ns after the following rising edge, so every comparison falls in the cycle the register stage fills. The effect of a symbol on the running disparity shows up on the next symbol instead. That is the upper lane in double-width mode, and the next clock otherwise. The bench therefore checks recovery and chaining on the symbol that follows the one that caused them, using an encoder model that tracks its own disparity.

// File: rtl/dec10_pkg.sv
package dec10_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              ctrl;
    logic              code_err;
    logic              disp_err;
  } lane_res_t;

  // 6-bit group abcdei (a in MSB) for the negative-disparity form
  function automatic logic [5:0] code6_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 4-bit group fghj (f in MSB), data, negative form, primary x.7
  function automatic logic [3:0] code4_neg(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  // 4-bit group for control characters, negative form
  function automatic logic [3:0] kcode4_neg(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b0110;
      3'd2: return 4'b1010;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b0101;
      3'd6: return 4'b1001;  default: return 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/dec10_lane.sv
module dec10_lane
  import dec10_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  input  logic             rd_i,
  output lane_res_t        res_o,
  output logic             rd_o
);
  logic [5:0] c6, e6v;
  logic [3:0] c4, e4v;
  logic [2:0] n6, n4;
  logic       hit6, hit4, k28, alt, err6, err4, bad7, rd_mid, cerr, kx7, a7x;
  logic [4:0] x;
  logic [2:0] y;

  always_comb begin
    c6 = {sym_i[0], sym_i[1], sym_i[2], sym_i[3], sym_i[4], sym_i[5]};
    c4 = {sym_i[6], sym_i[7], sym_i[8], sym_i[9]};
    n6 = 3'($countones(c6));
    n4 = 3'($countones(c4));
    hit6 = 1'b0; hit4 = 1'b0; k28 = 1'b0; alt = 1'b0;
    err6 = 1'b0; err4 = 1'b0; x = '0; y = '0; e6v = '0; e4v = '0;

    // 6-bit group
    if (c6 == 6'b001111 || c6 == 6'b110000) begin
      hit6 = 1'b1; k28 = 1'b1; x = 5'd28;
      err6 = (c6 == 6'b001111) ? rd_i : !rd_i;
    end else begin
      for (int i = 0; i < 32; i++) begin
        e6v = code6_neg(5'(i));
        if (c6 == e6v) begin
          hit6 = 1'b1; x = 5'(i);
          err6 = (n6 != 3'd3 || e6v == 6'b111000) && rd_i;
        end else if ((n6 != 3'd3 || e6v == 6'b111000) && c6 == ~e6v) begin
          hit6 = 1'b1; x = 5'(i);
          err6 = !rd_i;
        end
      end
    end
    rd_mid = (n6 > 3'd3) ? 1'b1 : (n6 < 3'd3) ? 1'b0 : rd_i;

    // 4-bit group
    if (k28) begin
      for (int j = 0; j < 8; j++) begin
        e4v = kcode4_neg(3'(j));
        if (c4 == (rd_mid ? ~e4v : e4v)) begin
          hit4 = 1'b1; y = 3'(j);
        end else if ((n4 != 3'd2 || j == 3) && c4 == (rd_mid ? e4v : ~e4v)) begin
          hit4 = 1'b1; y = 3'(j); err4 = 1'b1;
        end
      end
    end else if (c4 == 4'b0111 || c4 == 4'b1000) begin
      hit4 = 1'b1; alt = 1'b1; y = 3'd7;
      err4 = (c4 == 4'b0111) ? rd_mid : !rd_mid;
    end else begin
      for (int j = 0; j < 8; j++) begin
        e4v = code4_neg(3'(j));
        if (c4 == e4v) begin
          hit4 = 1'b1; y = 3'(j);
          err4 = (n4 != 3'd2 || j == 3) && rd_mid;
        end else if ((n4 != 3'd2 || j == 3) && c4 == ~e4v) begin
          hit4 = 1'b1; y = 3'(j);
          err4 = !rd_mid;
        end
      end
    end

    // x.7 form rules
    kx7  = !k28 && (x inside {5'd23, 5'd27, 5'd29, 5'd30});
    a7x  = (c4 == 4'b0111 && (x inside {5'd17, 5'd18, 5'd20})) ||
           (c4 == 4'b1000 && (x inside {5'd11, 5'd13, 5'd14}));
    bad7 = alt ? !(kx7 || a7x)
               : (!k28 && ((c4 == 4'b1110 && !rd_mid && (x inside {5'd17, 5'd18, 5'd20})) ||
                           (c4 == 4'b0001 &&  rd_mid && (x inside {5'd11, 5'd13, 5'd14}))));
    cerr = !hit6 || !hit4 || bad7;

    res_o.code_err = cerr;
    res_o.disp_err = !cerr && (err6 || err4);
    res_o.ctrl     = !cerr && (k28 || (alt && kx7));
    res_o.data     = cerr ? '0 : {y, x};
    rd_o = (n4 > 3'd2) ? 1'b1 : (n4 < 3'd2) ? 1'b0 : rd_mid;
  end
endmodule

// File: rtl/dec10_stage.sv
module dec10_stage
  import dec10_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  lane_res_t res_i,
  output lane_res_t res_o
);
  lane_res_t res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (en_i) res_q <= res_i;
    else           res_q <= '0;
  end
  assign res_o = res_q;

  assert_invalid_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q.code_err |-> (res_q.data == '0 && !res_q.ctrl));

  assert_flags_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_q.code_err && res_q.disp_err));

  assert_ctrl_is_k_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q.ctrl |-> (res_q.data[4:0] == 5'd28 ||
                    (res_q.data[7:5] == 3'd7 &&
                     (res_q.data[4:0] inside {5'd23, 5'd27, 5'd29, 5'd30}))));
endmodule

// File: rtl/dual_dec10b8b.sv
module dual_dec10b8b
  import dec10_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        dbl_i,
  input  logic [NUM_LANES*SYM_W-1:0]  sym_i,
  output logic [NUM_LANES*BYTE_W-1:0] data_o,
  output logic [NUM_LANES-1:0]        ctrl_o,
  output logic [NUM_LANES-1:0]        code_err_o,
  output logic [NUM_LANES-1:0]        disp_err_o
);
  localparam int OUT_W = NUM_LANES * BYTE_W;

  logic                 rd_q;
  logic [NUM_LANES:0]   rd_chain;
  lane_res_t            res [NUM_LANES];
  lane_res_t            res_q [NUM_LANES];

  assign rd_chain[0] = rd_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dec10_lane u_lane (
      .sym_i (sym_i[g*SYM_W +: SYM_W]),
      .rd_i  (rd_chain[g]),
      .res_o (res[g]),
      .rd_o  (rd_chain[g+1])
    );
    dec10_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   ((g == 0) ? 1'b1 : dbl_i),
      .res_i  (res[g]),
      .res_o  (res_q[g])
    );
    assign data_o[g*BYTE_W +: BYTE_W] = res_q[g].data;
    assign ctrl_o[g]     = res_q[g].ctrl;
    assign code_err_o[g] = res_q[g].code_err;
    assign disp_err_o[g] = res_q[g].disp_err;
  end

  // running disparity, negative after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= dbl_i ? rd_chain[NUM_LANES] : rd_chain[1];
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_single_upper_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(dbl_i)) |->
      (data_o[OUT_W-1:BYTE_W] == '0 && ctrl_o[NUM_LANES-1:1] == '0 &&
       code_err_o[NUM_LANES-1:1] == '0 && disp_err_o[NUM_LANES-1:1] == '0));
endmodule

// File: tb/test_dual_dec10b8b.sv
module test_dual_dec10b8b;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbl_i = 1'b0;
  logic [19:0] sym_i = '0;
  logic [15:0] data_o;
  logic [1:0]  ctrl_o, code_err_o, disp_err_o;
  int checks = 0;
  int errors = 0;
  logic rd_m = 1'b0;

  always #2 clk = ~clk;

  dual_dec10b8b i_dual_dec10b8b (
    .clk_i(clk), .rst_ni(rst_ni), .dbl_i(dbl_i), .sym_i(sym_i),
    .data_o(data_o), .ctrl_o(ctrl_o), .code_err_o(code_err_o), .disp_err_o(disp_err_o)
  );

  function automatic logic [5:0] t6(input logic [4:0] x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
      6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101,
      6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011, 6'b110010,
      6'b001011, 6'b101010, 6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110,
      6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction
  function automatic logic [3:0] t4(input logic [2:0] y);
    logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction
  function automatic logic [3:0] tk4(input logic [2:0] y);
    logic [3:0] t [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
    return t[y];
  endfunction

  function automatic logic [9:0] pack(input logic [5:0] c6, input logic [3:0] c4);
    return {c4[0], c4[1], c4[2], c4[3], c6[0], c6[1], c6[2], c6[3], c6[4], c6[5]};
  endfunction

  // reference encoder
  function automatic void enc(input logic [7:0] b, input logic k, input logic rd,
                              output logic [9:0] s, output logic rdn);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] e6, c6;
    logic [3:0] e4, c4;
    logic       rm;
    int         n;
    x = b[4:0]; y = b[7:5];
    e6 = t6(x);
    if (k && x == 5'd28) c6 = rd ? 6'b110000 : 6'b001111;
    else if ($countones(e6) != 3 || e6 == 6'b111000) c6 = rd ? ~e6 : e6;
    else c6 = e6;
    n = $countones(c6);
    rm = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : rd;
    if (k && x == 5'd28) begin
      e4 = tk4(y); c4 = rm ? ~e4 : e4;
    end else if (y == 3'd7 && (k || (!rm && (x inside {5'd17, 5'd18, 5'd20})) ||
                               (rm && (x inside {5'd11, 5'd13, 5'd14})))) begin
      c4 = rm ? 4'b1000 : 4'b0111;
    end else begin
      e4 = t4(y);
      c4 = ($countones(e4) != 2 || y == 3'd3) ? (rm ? ~e4 : e4) : e4;
    end
    n = $countones(c4);
    rdn = (n > 2) ? 1'b1 : (n < 2) ? 1'b0 : rm;
    s = pack(c6, c4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_lane(input string tag, input int ln, input logic [7:0] b, input logic k,
                          input logic ce, input logic de);
    chk({tag, " data"}, 32'(data_o[ln*8 +: 8]), 32'(b));
    chk({tag, " ctrl"}, 32'(ctrl_o[ln]), 32'(k));
    chk({tag, " code_err"}, 32'(code_err_o[ln]), 32'(ce));
    chk({tag, " disp_err"}, 32'(disp_err_o[ln]), 32'(de));
  endtask

  task automatic apply(input logic dbl, input logic [19:0] s);
    @(negedge clk);
    dbl_i = dbl; sym_i = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; dbl_i = 1'b0; sym_i = '0;
    #1;
    chk("R11 reset data", 32'(data_o), 0);
    chk("R11 reset flags", 32'({ctrl_o, code_err_o, disp_err_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd_m = 1'b0;
  endtask

  task automatic t_single_data();
    logic [9:0] s;
    logic       r;
    do_reset();
    for (int i = 0; i < 256; i++) begin
      enc(8'(i), 1'b0, rd_m, s, r);
      rd_m = r;
      apply(1'b0, {10'(i * 37 + 5), s});
      chk_lane("R1 single data", 0, 8'(i), 1'b0, 1'b0, 1'b0);
      chk("R8 upper quiet", 32'({data_o[15:8], ctrl_o[1], code_err_o[1], disp_err_o[1]}), 0);
    end
  endtask

  task automatic t_kcodes();
    logic [7:0] kl [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                            8'hF7, 8'hFB, 8'hFD, 8'hFE};
    logic [9:0] s;
    logic       r;
    for (int i = 0; i < 12; i++) begin
      enc(kl[i], 1'b1, rd_m, s, r);
      rd_m = r;
      apply(1'b0, {10'h0, s});
      chk_lane("R3 control", 0, kl[i], 1'b1, 1'b0, 1'b0);
    end
    enc(8'hBC, 1'b1, 1'b1, s, r);
    chk("R3 K28.5 positive form", 32'(s), 32'(pack(6'b110000, 4'b0101)));
  endtask

  task automatic t_double();
    logic [9:0] s0, s1;
    logic       r1, r2;
    logic [7:0] b0, b1;
    logic       k1;
    do_reset();
    for (int i = 0; i < 128; i++) begin
      b0 = 8'(i * 3 + 1);
      k1 = (i % 16 == 0);
      b1 = k1 ? 8'hBC : 8'(255 - i);
      enc(b0, 1'b0, rd_m, s0, r1);
      enc(b1, k1, r1, s1, r2);
      rd_m = r2;
      apply(1'b1, {s1, s0});
      chk_lane("R2 lower lane", 0, b0, 1'b0, 1'b0, 1'b0);
      chk_lane("R7 upper lane chained", 1, b1, k1, 1'b0, 1'b0);
    end
  endtask

  task automatic t_invalid();
    logic [9:0] s;
    logic       r;
    do_reset();
    enc(8'hF1, 1'b0, rd_m, s, r);
    rd_m = r;
    apply(1'b0, {10'h0, s});
    chk_lane("R10 D17.7 alternate legal", 0, 8'hF1, 1'b0, 1'b0, 1'b0);
    enc(8'hF7, 1'b1, rd_m, s, r);
    rd_m = r;
    apply(1'b0, {10'h0, s});
    chk_lane("R10 K23.7", 0, 8'hF7, 1'b1, 1'b0, 1'b0);
    do_reset();
    apply(1'b0, {10'h0, pack(6'b100011, 4'b1110)});
    chk_lane("R10 primary x.7 after D17", 0, 8'h00, 1'b0, 1'b1, 1'b0);
    do_reset();
    apply(1'b0, {10'h0, pack(6'b101001, 4'b0111)});
    chk_lane("R10 alternate after D5", 0, 8'h00, 1'b0, 1'b1, 1'b0);
    apply(1'b0, {10'h0, 10'h000});
    chk_lane("R4 all zeros", 0, 8'h00, 1'b0, 1'b1, 1'b0);
    apply(1'b0, {10'h0, 10'h3FF});
    chk_lane("R4 all ones", 0, 8'h00, 1'b0, 1'b1, 1'b0);
    do_reset();
    apply(1'b1, {10'h3FF, pack(6'b100111, 4'b0100)});
    chk_lane("R4 lower legal", 0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk_lane("R4 upper illegal", 1, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_disp();
    logic [9:0] s0, s1;
    logic       r1, r2;
    do_reset();
    enc(8'h81, 1'b0, 1'b1, s0, r1);
    rd_m = r1;
    apply(1'b0, {10'h0, s0});
    chk_lane("R5 wrong form after reset", 0, 8'h81, 1'b0, 1'b0, 1'b1);
    enc(8'h42, 1'b0, rd_m, s0, r1);
    rd_m = r1;
    apply(1'b0, {10'h0, s0});
    chk_lane("R6 recovery", 0, 8'h42, 1'b0, 1'b0, 1'b0);
    enc(8'h55, 1'b0, rd_m, s0, r1);
    enc(8'h81, 1'b0, !r1, s1, r2);
    rd_m = r2;
    apply(1'b1, {s1, s0});
    chk_lane("R7 lower clean", 0, 8'h55, 1'b0, 1'b0, 1'b0);
    chk_lane("R7 upper wrong form", 1, 8'h81, 1'b0, 1'b0, 1'b1);
    enc(8'h07, 1'b0, rd_m, s0, r1);
    rd_m = r1;
    apply(1'b0, {10'h0, s0});
    chk_lane("R6 carry after upper error", 0, 8'h07, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mode_switch();
    logic [9:0] s0, s1;
    logic       r1, r2;
    logic [7:0] b0, b1;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      b0 = 8'(i * 11 + 2);
      b1 = 8'(i * 29 + 7);
      enc(b0, 1'b0, rd_m, s0, r1);
      if (i % 2 == 1) begin
        enc(b1, 1'b0, r1, s1, r2);
        rd_m = r2;
        apply(1'b1, {s1, s0});
        chk_lane("R9 double word", 0, b0, 1'b0, 1'b0, 1'b0);
        chk_lane("R9 double upper", 1, b1, 1'b0, 1'b0, 1'b0);
      end else begin
        rd_m = r1;
        apply(1'b0, {10'h3FF, s0});
        chk_lane("R9 single word", 0, b0, 1'b0, 1'b0, 1'b0);
        chk_lane("R9 single upper quiet R8", 1, 8'h00, 1'b0, 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_single_data();
    t_kcodes();
    t_double();
    t_invalid();
    t_disp();
    t_mode_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule